// File: doc/BRIEF.md
# UART Receive FIFO and Channel Router

This block is the byte-level data path of a serial port. It sits between three parties: the deserialised receive stream, the host-side data register, and the transmit queue. It keeps a circular receive FIFO, tracked by a write pointer and an occupancy count. A two-bit channel mode decides where each incoming serial byte and each host data write goes. The two sides can be looped back onto each other, in either direction, for diagnostics.

A control register holds four gate bits: enable and disable for the receive side, and enable and disable for the transmit side. Two further bits are one-shot flushes. Bytes that reach a full FIFO are dropped and reported with an overrun pulse. An idle timer produces a receive timeout pulse when four character times pass after the last accepted byte. The timer is a small state machine with states `TMR_IDLE` and `TMR_RUN`. The transition *arm* goes from IDLE to RUN on an accepted byte. The transition *rearm* stays in RUN and reloads the timer on each further byte. The transition *expire* goes from RUN to IDLE when the count runs out, and fires the pulse. The transition *cancel* goes from RUN to IDLE on a receive flush.

Top module: `uart_rx_route`

## Requirements
- R1: After reset the control register reads 0x128, the FIFO count is 0, and `rd_data`, `tx_push`, `tx_data`, `tx_flush`, `ovr_pulse` and `tmo_pulse` are all 0.
- R2: The channel mode is encoded as 0 normal, 1 echo, 2 local loopback and 3 remote loopback. A serial byte is pushed into the receive FIFO in modes 0 and 1. It is forwarded on `tx_push`/`tx_data` in modes 1 and 3. In mode 2 it is ignored.
- R3: A host data write is forwarded to the transmit queue in mode 0. It is pushed into the receive FIFO in mode 2. In modes 1 and 3 it is discarded.
- R4: Receive pushes and pops take effect only while control bit 2 is 1 and bit 3 is 0. Transmit forwarding takes effect only while bit 4 is 1 and bit 5 is 0. A set disable bit overrides its enable bit. A read while receive is gated off returns 0 and leaves the count unchanged.
- R5: A byte that arrives for the receive FIFO while it holds DEPTH entries is dropped. The count stays at DEPTH, and `ovr_pulse` is 1 for exactly the cycle after that edge.
- R6: A host read returns the oldest byte on `rd_data` in the cycle after the read edge, and decrements the count. A read of an empty FIFO returns 0.
- R7: Each accepted receive byte restarts a timer of 4×`char_time` cycles. `tmo_pulse` rises exactly 4×`char_time` edges after the last accepted byte's edge, and only if `timeout_val` is non-zero at the expiring edge.
- R8: Writing control bit 0 empties the receive FIFO and stops the timer. Writing bit 1 gives a one-cycle `tx_flush` pulse. Neither bit is stored: the register reads back with bits 1:0 clear.
- R9: The FIFO wraps around its storage: order is preserved when the write pointer passes the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mode | input | 2 | Channel mode (0 normal, 1 echo, 2 local loop, 3 remote loop) |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control write value (bit0 rx flush, bit1 tx flush, bit2 rx enable, bit3 rx disable, bit4 tx enable, bit5 tx disable) |
| ctrl_rd | output | 9 | Current control register value |
| ser_valid | input | 1 | Received serial byte strobe |
| ser_data | input | 8 | Received serial byte |
| host_wr | input | 1 | Host data-register write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data-register read strobe |
| rd_data | output | 8 | Read result, valid the cycle after `host_rd` |
| rx_count | output | CW | Receive FIFO occupancy |
| char_time | input | 16 | Clock cycles per character |
| timeout_val | input | 8 | Timeout setting; 0 suppresses the timeout pulse |
| tx_push | output | 1 | Byte forwarded to transmit queue |
| tx_data | output | 8 | Forwarded byte (0 when no push) |
| tx_flush | output | 1 | Transmit queue flush pulse |
| ovr_pulse | output | 1 | Receive overrun pulse |
| tmo_pulse | output | 1 | Receive timeout pulse |

## Verification
The bound assertions check, on every cycle, the properties that need no history beyond one cycle. These are: the count never exceeds the depth and moves by at most one except on a flush; overruns occur only from a full FIFO; forwarding happens only with transmit enabled and never in local loopback; empty reads return 0; a timeout pulse occurs only with a non-zero setting. Only the bench's scenarios can show the rest. That covers the mode-dependent routing of particular bytes, the data order through pointer wraparound, reads being refused while receive is gated off, and the exact 4×`char_time` cycle position of the timeout pulse. The bench shows these with directed sequences and with a queue-based model compared on every clock during a randomised phase.

// File: rtl/uart_route_pkg.sv
package uart_route_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    localparam int CTRL_W           = 9;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
    localparam int CB_RX_FLUSH      = 0;
    localparam int CB_TX_FLUSH      = 1;
    localparam int CB_RX_ON         = 2;
    localparam int CB_RX_OFF        = 3;
    localparam int CB_TX_ON         = 4;
    localparam int CB_TX_OFF        = 5;

endpackage

// File: rtl/uart_route_steer.sv
module uart_route_steer
    import uart_route_pkg::*;
#(
    parameter int DW = 8
) (
    input  chan_mode_e     mode,
    input  logic           rx_on,
    input  logic           tx_on,
    input  logic           ser_valid,
    input  logic [DW-1:0]  ser_data,
    input  logic           host_wr,
    input  logic [DW-1:0]  host_wdata,
    output logic           fifo_push,
    output logic [DW-1:0]  fifo_din,
    output logic           txq_push,
    output logic [DW-1:0]  txq_din
);

    logic          rx_req;
    logic          tx_req;

    always_comb begin
        rx_req   = 1'b0;
        fifo_din = '0;
        tx_req   = 1'b0;
        txq_din  = '0;
        unique case (mode)
            CH_NORMAL: begin
                rx_req   = ser_valid;
                fifo_din = ser_data;
                tx_req   = host_wr;
                txq_din  = host_wdata;
            end
            CH_ECHO: begin
                rx_req   = ser_valid;
                fifo_din = ser_data;
                tx_req   = ser_valid;
                txq_din  = ser_data;
            end
            CH_LOCAL: begin
                rx_req   = host_wr;
                fifo_din = host_wdata;
            end
            CH_REMOTE: begin
                tx_req   = ser_valid;
                txq_din  = ser_data;
            end
        endcase
    end

    assign fifo_push = rx_req & rx_on;
    assign txq_push  = tx_req & tx_on;

endmodule

// File: rtl/uart_route_fifo.sv
module uart_route_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push,
    input  logic [DW-1:0]  din,
    input  logic           rd_req,
    input  logic           rd_en,
    output logic [DW-1:0]  rd_data,
    output logic [CW-1:0]  count,
    output logic           accepted,
    output logic           overrun
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rd_q;
    logic          ovr_q;
    logic          full;
    logic          pop_ok;
    logic [CW:0]   rsum;
    logic [AW-1:0] rptr;
    logic [AW-1:0] wptr_nx;

    assign full     = (cnt_q == CW'(DEPTH));
    assign accepted = push & ~full & ~flush;
    assign pop_ok   = rd_req & rd_en & (cnt_q != '0) & ~flush;

    // oldest entry sits count places behind the write pointer
    always_comb begin
        rsum = (CW+1)'(wptr_q) + (CW+1)'(DEPTH) - (CW+1)'(cnt_q);
        if (rsum >= (CW+1)'(DEPTH)) begin
            rptr = AW'(rsum - (CW+1)'(DEPTH));
        end else begin
            rptr = AW'(rsum);
        end
        wptr_nx = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (accepted) begin
            mem[wptr_q] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
            rd_q   <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (rd_req) begin
                rd_q <= (rd_en && cnt_q != '0) ? mem[rptr] : '0;
            end
            if (flush) begin
                wptr_q <= '0;
                cnt_q  <= '0;
                ovr_q  <= 1'b0;
            end else begin
                ovr_q <= push & full;
                if (accepted) begin
                    wptr_q <= wptr_nx;
                end
                unique case ({accepted, pop_ok})
                    2'b10:   cnt_q <= cnt_q + CW'(1);
                    2'b01:   cnt_q <= cnt_q - CW'(1);
                    default: cnt_q <= cnt_q;
                endcase
            end
        end
    end

    assign rd_data = rd_q;
    assign count   = cnt_q;
    assign overrun = ovr_q;

endmodule

// File: rtl/uart_route_idle_timer.sv
module uart_route_idle_timer
    import uart_route_pkg::*;
#(
    parameter int CTW = 16,
    localparam int TW = CTW + 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           kick,
    input  logic           cancel,
    input  logic [CTW-1:0] char_time,
    input  logic           cfg_nz,
    output logic           fire
);

    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] reload;
    logic          expire;
    logic          fire_q;

    assign reload = {char_time, 2'b00};

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            TMR_IDLE: begin
                if (kick && reload != '0) begin
                    state_d = TMR_RUN;
                    cnt_d   = reload;
                end
            end
            TMR_RUN: begin
                if (cancel) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else if (kick) begin
                    state_d = (reload != '0) ? TMR_RUN : TMR_IDLE;
                    cnt_d   = reload;
                end else if (cnt_q == TW'(1)) begin
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                    expire  = 1'b1;
                end else begin
                    cnt_d   = cnt_q - TW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= expire & cfg_nz;
        end
    end

    assign fire = fire_q;

endmodule

// File: rtl/uart_rx_route.sv
module uart_rx_route
    import uart_route_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int CTW   = 16,
    parameter int TOW   = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_rd,
    input  logic              ser_valid,
    input  logic [DW-1:0]     ser_data,
    input  logic              host_wr,
    input  logic [DW-1:0]     host_wdata,
    input  logic              host_rd,
    output logic [DW-1:0]     rd_data,
    output logic [CW-1:0]     rx_count,
    input  logic [CTW-1:0]    char_time,
    input  logic [TOW-1:0]    timeout_val,
    output logic              tx_push,
    output logic [DW-1:0]     tx_data,
    output logic              tx_flush,
    output logic              ovr_pulse,
    output logic              tmo_pulse
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              rx_on, tx_on, rx_flush;
    logic              fifo_push, txq_push, accepted;
    logic [DW-1:0]     fifo_din, txq_din;
    logic              tx_push_q, tx_flush_q;
    logic [DW-1:0]     tx_data_q;
    logic [CTRL_W-1:0] self_clear;

    assign self_clear = CTRL_W'((1 << CB_RX_FLUSH) | (1 << CB_TX_FLUSH));
    assign rx_on    = ctrl_q[CB_RX_ON] & ~ctrl_q[CB_RX_OFF];
    assign tx_on    = ctrl_q[CB_TX_ON] & ~ctrl_q[CB_TX_OFF];
    assign rx_flush = ctrl_wr & ctrl_wdata[CB_RX_FLUSH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= CTRL_RESET;
            tx_flush_q <= 1'b0;
            tx_push_q  <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= ctrl_wdata & ~self_clear;
            end
            tx_flush_q <= ctrl_wr & ctrl_wdata[CB_TX_FLUSH];
            tx_push_q  <= txq_push;
            tx_data_q  <= txq_push ? txq_din : '0;
        end
    end

    uart_route_steer #(.DW(DW)) u_steer (
        .mode       (chan_mode_e'(chan_mode)),
        .rx_on      (rx_on),
        .tx_on      (tx_on),
        .ser_valid  (ser_valid),
        .ser_data   (ser_data),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .fifo_push  (fifo_push),
        .fifo_din   (fifo_din),
        .txq_push   (txq_push),
        .txq_din    (txq_din)
    );

    uart_route_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .push     (fifo_push),
        .din      (fifo_din),
        .rd_req   (host_rd),
        .rd_en    (rx_on),
        .rd_data  (rd_data),
        .count    (rx_count),
        .accepted (accepted),
        .overrun  (ovr_pulse)
    );

    uart_route_idle_timer #(.CTW(CTW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (accepted),
        .cancel    (rx_flush),
        .char_time (char_time),
        .cfg_nz    (timeout_val != '0),
        .fire      (tmo_pulse)
    );

    assign ctrl_rd  = ctrl_q;
    assign tx_push  = tx_push_q;
    assign tx_data  = tx_data_q;
    assign tx_flush = tx_flush_q;

endmodule

// File: rtl/uart_rx_route_chk.sv
module uart_rx_route_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = 7,
    parameter int TOW   = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    chan_mode,
    input logic          ctrl_wr,
    input logic [8:0]    ctrl_wdata,
    input logic [8:0]    ctrl_rd,
    input logic          host_rd,
    input logic [7:0]    rd_data,
    input logic [CW-1:0] rx_count,
    input logic [TOW-1:0] timeout_val,
    input logic          tx_push,
    input logic          ovr_pulse,
    input logic          tmo_pulse
);

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_count) <= DEPTH);  // R5

    AST_OVR_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ovr_pulse |-> int'($past(rx_count)) == DEPTH);  // R5

    AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        tx_push |-> $past(ctrl_rd[4] && !ctrl_rd[5]));  // R4

    AST_LOCAL_NO_TX: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        tx_push |-> $past(chan_mode) != 2'd2);  // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        !$past(ctrl_wr && ctrl_wdata[0]) |->
            (int'(rx_count) <= int'($past(rx_count)) + 1) &&
            (int'(rx_count) + 1 >= int'($past(rx_count))));  // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(ctrl_wr && ctrl_wdata[0]) |-> (rx_count == '0) && !ovr_pulse);  // R8

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(host_rd && rx_count == '0) |-> rd_data == 8'd0);  // R6

    AST_TMO_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        tmo_pulse |-> $past(timeout_val != '0));  // R7

endmodule

bind uart_rx_route uart_rx_route_chk #(.DEPTH(DEPTH), .CW(CW), .TOW(TOW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_mode   (chan_mode),
    .ctrl_wr     (ctrl_wr),
    .ctrl_wdata  (ctrl_wdata),
    .ctrl_rd     (ctrl_rd),
    .host_rd     (host_rd),
    .rd_data     (rd_data),
    .rx_count    (rx_count),
    .timeout_val (timeout_val),
    .tx_push     (tx_push),
    .ovr_pulse   (ovr_pulse),
    .tmo_pulse   (tmo_pulse)
);

// File: tb/test_uart_rx_route.sv
`timescale 1ns/1ps
module test_uart_rx_route;

    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    chan_mode = 2'd0;
    logic          ctrl_wr = 1'b0;
    logic [8:0]    ctrl_wdata = '0;
    logic [8:0]    ctrl_rd;
    logic          ser_valid = 1'b0;
    logic [7:0]    ser_data = '0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic          host_rd = 1'b0;
    logic [7:0]    rd_data;
    logic [CW-1:0] rx_count;
    logic [15:0]   char_time = 16'd3;
    logic [7:0]    timeout_val = 8'd0;
    logic          tx_push, tx_flush, ovr_pulse, tmo_pulse;
    logic [7:0]    tx_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_rx_route #(.DEPTH(DEPTH)) i_uart_rx_route (
        .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rd(ctrl_rd),
        .ser_valid(ser_valid), .ser_data(ser_data),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .rd_data(rd_data), .rx_count(rx_count),
        .char_time(char_time), .timeout_val(timeout_val),
        .tx_push(tx_push), .tx_data(tx_data), .tx_flush(tx_flush),
        .ovr_pulse(ovr_pulse), .tmo_pulse(tmo_pulse)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   q[$];
    int   e_rd, e_txd, tmr;
    bit   e_txv, e_ovr, e_tmo, e_txf, live;
    bit [8:0] e_ctrl;

    always @(posedge clk) begin
        bit rxen, txen, fl, full, prq, acc, tq;
        int pb, tb;
        if (!rst_n) begin
            q.delete();
            e_rd = 0; e_txd = 0; tmr = 0;
            e_txv = 0; e_ovr = 0; e_tmo = 0; e_txf = 0;
            e_ctrl = 9'h128; live = 0;
        end else begin
            live = 1;
            rxen = e_ctrl[2] && !e_ctrl[3];
            txen = e_ctrl[4] && !e_ctrl[5];
            fl   = ctrl_wr && ctrl_wdata[0];
            full = (q.size() == DEPTH);
            prq = 0; pb = 0; tq = 0; tb = 0;
            if (ser_valid && (chan_mode == 2'd0 || chan_mode == 2'd1)) begin prq = 1; pb = ser_data; end
            if (host_wr && chan_mode == 2'd2) begin prq = 1; pb = host_wdata; end
            if (host_wr && chan_mode == 2'd0) begin tq = 1; tb = host_wdata; end
            if (ser_valid && (chan_mode == 2'd1 || chan_mode == 2'd3)) begin tq = 1; tb = ser_data; end
            prq = prq && rxen;
            if (host_rd) e_rd = (rxen && q.size() > 0) ? q[0] : 0;
            e_txv = tq && txen;
            e_txd = e_txv ? tb : 0;
            if (fl) begin
                q.delete();
                e_ovr = 0; e_tmo = 0; tmr = 0;
            end else begin
                acc   = prq && !full;
                e_ovr = prq && full;
                if (host_rd && rxen && q.size() > 0) void'(q.pop_front());
                if (acc) q.push_back(pb);
                e_tmo = (tmr == 1) && !acc && (timeout_val != 0);
                if (acc) tmr = 4 * int'(char_time);
                else if (tmr > 0) tmr--;
            end
            e_txf = ctrl_wr && ctrl_wdata[1];
            if (ctrl_wr) e_ctrl = ctrl_wdata & 9'h1FC;
        end
    end

    always @(negedge clk) begin
        if (rst_n && live && !done) begin
            chk("model R6 rx_count", int'(rx_count), q.size());
            chk("model R6 rd_data", int'(rd_data), e_rd);
            chk("model R2 tx_push", int'(tx_push), int'(e_txv));
            chk("model R3 tx_data", int'(tx_data), e_txd);
            chk("model R5 ovr_pulse", int'(ovr_pulse), int'(e_ovr));
            chk("model R7 tmo_pulse", int'(tmo_pulse), int'(e_tmo));
            chk("model R8 tx_flush", int'(tx_flush), int'(e_txf));
            chk("model R8 ctrl_rd", int'(ctrl_rd), int'(e_ctrl));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic send_ser(input logic [7:0] b);
        ser_valid = 1'b1; ser_data = b;
        @(negedge clk);
        ser_valid = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] b);
        host_wr = 1'b1; host_wdata = b;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(output int v);
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        v = int'(rd_data);
    endtask

    task automatic ctrl_write(input logic [8:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        int v, first, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ctrl reset", int'(ctrl_rd), 'h128);
        chk("R1 count reset", int'(rx_count), 0);
        chk("R1 tx_push reset", int'(tx_push), 0);
        chk("R1 pulses reset", int'(ovr_pulse | tmo_pulse | tx_flush), 0);

        // gated off by reset value
        send_ser(8'h11);
        chk("R4 rx disabled ignores byte", int'(rx_count), 0);
        host_write(8'h22);
        chk("R4 tx disabled no forward", int'(tx_push), 0);

        ctrl_write(9'h014);
        // normal
        chan_mode = 2'd0;
        send_ser(8'hA1);
        chk("R2 normal serial to fifo", int'(rx_count), 1);
        send_ser(8'hA2);
        host_write(8'h5C);
        chk("R3 normal host to tx push", int'(tx_push), 1);
        chk("R3 normal host to tx data", int'(tx_data), 'h5C);
        chk("R3 normal host not in fifo", int'(rx_count), 2);
        host_read(v); chk("R6 first byte", v, 'hA1);
        host_read(v); chk("R6 second byte", v, 'hA2);
        host_read(v); chk("R6 empty read zero", v, 0);
        chk("R6 count after drain", int'(rx_count), 0);

        // echo
        chan_mode = 2'd1;
        send_ser(8'h33);
        chk("R2 echo tx push", int'(tx_push), 1);
        chk("R2 echo tx data", int'(tx_data), 'h33);
        chk("R2 echo fifo", int'(rx_count), 1);
        host_write(8'h44);
        chk("R3 echo host discarded tx", int'(tx_push), 0);
        chk("R3 echo host discarded fifo", int'(rx_count), 1);
        host_read(v); chk("R2 echo byte", v, 'h33);

        // local loopback
        chan_mode = 2'd2;
        send_ser(8'h55);
        chk("R2 local serial ignored", int'(rx_count), 0);
        chk("R2 local serial no tx", int'(tx_push), 0);
        host_write(8'h66);
        chk("R3 local host to fifo", int'(rx_count), 1);
        chk("R3 local host no tx", int'(tx_push), 0);
        host_read(v); chk("R3 local byte", v, 'h66);

        // remote loopback
        chan_mode = 2'd3;
        send_ser(8'h77);
        chk("R2 remote tx push", int'(tx_push), 1);
        chk("R2 remote tx data", int'(tx_data), 'h77);
        chk("R2 remote no fifo", int'(rx_count), 0);
        host_write(8'h88);
        chk("R3 remote host discarded", int'(tx_push), 0);

        // disable overrides enable
        ctrl_write(9'h03C);
        chan_mode = 2'd1;
        send_ser(8'h99);
        chk("R4 rx disable wins", int'(rx_count), 0);
        chk("R4 tx disable wins", int'(tx_push), 0);
        ctrl_write(9'h014);
        chan_mode = 2'd0;
        send_ser(8'h12);
        ctrl_write(9'h01C);
        host_read(v);
        chk("R4 gated read zero", v, 0);
        chk("R4 gated read keeps count", int'(rx_count), 1);
        ctrl_write(9'h014);
        host_read(v); chk("R4 read after reenable", v, 'h12);

        // overrun
        for (int i = 0; i < DEPTH; i++) send_ser(8'(i + 1));
        chk("R5 full count", int'(rx_count), DEPTH);
        send_ser(8'hEE);
        chk("R5 overrun pulse", int'(ovr_pulse), 1);
        chk("R5 count held", int'(rx_count), DEPTH);
        @(negedge clk);
        chk("R5 pulse one cycle", int'(ovr_pulse), 0);

        // wraparound
        for (int i = 0; i < 10; i++) begin
            host_read(v); chk("R9 pre-wrap order", v, i + 1);
        end
        for (int i = 0; i < 10; i++) send_ser(8'(8'hC0 + i));
        for (int i = 0; i < DEPTH; i++) begin
            host_read(v);
            chk("R9 wrap order", v, (i < DEPTH - 10) ? i + 11 : 'hC0 + i - (DEPTH - 10));
        end
        chk("R9 drained", int'(rx_count), 0);

        // flushes
        send_ser(8'h01); send_ser(8'h02); send_ser(8'h03);
        ctrl_write(9'h015);
        chk("R8 rx flush empties", int'(rx_count), 0);
        chk("R8 self clear rx bit", int'(ctrl_rd), 'h014);
        ctrl_write(9'h016);
        chk("R8 tx flush pulse", int'(tx_flush), 1);
        chk("R8 self clear tx bit", int'(ctrl_rd), 'h014);
        @(negedge clk);
        chk("R8 tx flush one cycle", int'(tx_flush), 0);

        // timeout
        char_time = 16'd5; timeout_val = 8'd7;
        send_ser(8'h42);
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (tmo_pulse && first == 0) first = k;
        end
        chk("R7 timeout position", first, 20);
        send_ser(8'h43);
        repeat (9) @(negedge clk);
        send_ser(8'h44);
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (tmo_pulse && first == 0) first = k;
        end
        chk("R7 restart on byte", first, 20);
        timeout_val = 8'd0;
        send_ser(8'h45);
        pulses = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (tmo_pulse) pulses++;
        end
        chk("R7 zero setting no pulse", pulses, 0);
        ctrl_write(9'h015);

        // randomised phase checked against the model every clock
        for (int c = 0; c < 3000; c++) begin
            if (c % 400 == 0) chan_mode = 2'($urandom);
            ser_valid  = ($urandom % 3) == 0;
            ser_data   = 8'($urandom);
            host_wr    = ($urandom % 4) == 0;
            host_wdata = 8'($urandom);
            host_rd    = ($urandom % 4) == 0;
            ctrl_wr    = ($urandom % 40) == 0;
            ctrl_wdata = 9'h014 | (($urandom % 4 == 0) ? 9'(($urandom % 2) ? 9'h008 : 9'h020) : 9'h000)
                         | (($urandom % 5 == 0) ? 9'($urandom % 4) : 9'h000);
            char_time  = 16'(1 + $urandom % 3);
            timeout_val = 8'($urandom % 2);
            @(negedge clk);
        end
        ser_valid = 0; host_wr = 0; host_rd = 0; ctrl_wr = 0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule